// File: doc/BRIEF.md
# GPIO configuration lock controller

This block guards the configuration of a 16-pin general-purpose I/O port. It holds one lock flag per pin and a single key flag, all reached through a small 32-bit register interface with byte strobes. Software selects the pins to protect by writing their lock flags, then commits the choice with three full-word writes to the key bit: one, zero, one. The lock flags must keep the same value across all three writes. When the key becomes active, every pin whose lock flag is set is frozen until reset.

The block also holds the port's mode/control word (2 bits per pin) and two alternate-function words (4 bits per pin, pins 0-7 and pins 8-15). These are plain storage here. They exist so that the per-pin write gating driven by the lock can be seen at the register interface. Reads return data one cycle after the read request.

Register word addresses: 0 is the lock register, 1 is the mode word, 2 is the alternate-function word for pins 0-7, and 3 is the alternate-function word for pins 8-15.

Top module: `pin_cfg_lock`

## Requirements
- R1: After reset every register reads as zero and `pin_frozen` is zero.
- R2: While the key is inactive, a write to address 0 updates the lock flags (bits [15:0]) in the bytes whose strobe is set. The read data returns the lock flags in bits [15:0], the key in bit 16, and zero in bits [31:17].
- R3: Three full-word writes to address 0 commit the lock: bit 16 set, then bit 16 clear, then bit 16 set, with equal bits [15:0] in all three. From the clock edge that accepts the third write, bit 16 reads 1 and `pin_frozen` equals the committed lock flags.
- R4: If bits [15:0] of a later write differ from the first write of the sequence, the sequence is aborted and the key stays inactive.
- R5: A write to address 0 whose strobes are not all set is a sequence error and never activates the key. Its strobed lock-flag bytes are still written.
- R6: A write that breaks the one-zero-one order aborts the sequence and returns the tracker to idle. A later full write with bit 16 set starts a fresh sequence.
- R7: A write with bit 16 clear, made while the tracker is idle, only updates the lock flags and does not advance the sequence. No single write sets the key.
- R8: Reads issued between the writes of a sequence do not disturb it.
- R9: Once the key is active, writes to address 0 change neither the lock flags nor the key, and a repeated sequence has no effect.
- R10: The mode and alternate-function words are written under byte strobes and read back as written.
- R11: While a pin is frozen, writes to its field in the mode word (bits [2p+1:2p]) and in its alternate-function word (4 bits, at position 4·(p mod 8)) are dropped. Fields of other pins in the same write are still updated.
- R12: Only reset clears the key and the lock flags. After reset the lock flags can be written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request for the addressed word |
| rd_en | input | 1 | Read request for the addressed word |
| addr | input | 2 | Word address (0 lock, 1 mode, 2-3 alternate function) |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte strobes for the write |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pin_frozen | output | 16 | Per-pin configuration freeze, high where the pin is locked |

## Verification
A write takes effect at the clock edge that accepts it. The lock commit therefore shows on `pin_frozen` right after the edge that takes the third key write, and the bench samples it on the following falling edge. Read data appears one edge after `rd_en` is sampled. The bench queues the expected word when it issues a read, and a monitor compares the queued value on the falling edge after that capture. Every abort case is observed through a read of bit 16 and of the lock flags, and through the frozen output, before the next stimulus.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
    // Progress of the key commit sequence
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ARMED   = 2'd1,  // first write (key=1) accepted
        SEQ_CLEARED = 2'd2   // second write (key=0) accepted
    } seq_state_e;

    localparam int unsigned ADDR_LOCK    = 0;
    localparam int unsigned ADDR_MODE    = 1;
    localparam int unsigned ADDR_AF_BASE = 2;
endpackage

// File: rtl/pcl_lock_seq.sv
module pcl_lock_seq
    import pcl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hit,
    input  logic [DATA_W/8-1:0]   wstrb,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM_PINS-1:0]   lock_bits,
    output logic                  key_on
);
    localparam int unsigned KEY_BIT = NUM_PINS;

    typedef struct packed {
        seq_state_e           st;
        logic [NUM_PINS-1:0]  held;
        logic [NUM_PINS-1:0]  lock;
        logic                 key;
    } seq_t;

    seq_t s_d, s_q;

    logic                full_word;
    logic                key_in;
    logic [NUM_PINS-1:0] val_in;
    logic [NUM_PINS-1:0] byte_mask;

    always_comb begin
        full_word = &wstrb;
        key_in    = wdata[KEY_BIT];
        val_in    = wdata[NUM_PINS-1:0];
        for (int i = 0; i < NUM_PINS; i++) begin
            byte_mask[i] = wstrb[i/8];
        end

        s_d = s_q;
        if (wr_hit && !s_q.key) begin
            s_d.lock = (s_q.lock & ~byte_mask) | (val_in & byte_mask);
            unique case (s_q.st)
                SEQ_IDLE: begin
                    if (full_word && key_in) begin
                        s_d.st   = SEQ_ARMED;
                        s_d.held = val_in;
                    end
                end
                SEQ_ARMED: begin
                    if (full_word && !key_in && (val_in == s_q.held)) begin
                        s_d.st = SEQ_CLEARED;
                    end else begin
                        s_d.st = SEQ_IDLE;
                    end
                end
                SEQ_CLEARED: begin
                    s_d.st = SEQ_IDLE;
                    if (full_word && key_in && (val_in == s_q.held)) begin
                        s_d.key = 1'b1;
                    end
                end
                default: s_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_bits = s_q.lock;
    assign key_on    = s_q.key;
endmodule

// File: rtl/pcl_cfg_word.sv
module pcl_cfg_word #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_hit,
    input  logic [DATA_W/8-1:0]           wstrb,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [DATA_W/FIELD_W-1:0]     field_frozen,
    output logic [DATA_W-1:0]             word
);
    localparam int unsigned NUM_FIELDS = DATA_W / FIELD_W;
    localparam int unsigned STRB_W     = DATA_W / 8;

    logic [DATA_W-1:0] frz_bits;
    logic [DATA_W-1:0] strb_bits;
    logic [DATA_W-1:0] wr_bits;
    logic [DATA_W-1:0] word_d, word_q;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign frz_bits[f*FIELD_W +: FIELD_W] = {FIELD_W{field_frozen[f]}};
    end

    for (genvar b = 0; b < STRB_W; b++) begin : g_byte
        assign strb_bits[b*8 +: 8] = {8{wstrb[b]}};
    end

    always_comb begin
        wr_bits = strb_bits & ~frz_bits;
        word_d  = word_q;
        if (wr_hit) begin
            word_d = (word_q & ~wr_bits) | (wdata & wr_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/pin_cfg_lock.sv
module pin_cfg_lock
    import pcl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MODE_W   = 2,
    parameter int unsigned AF_W     = 4,
    parameter int unsigned ADDR_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   wstrb,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_PINS-1:0]   pin_frozen
);
    localparam int unsigned AF_PER_WORD = DATA_W / AF_W;
    localparam int unsigned AF_WORDS    = NUM_PINS / AF_PER_WORD;

    logic [NUM_PINS-1:0] lock_bits;
    logic                key_on;
    logic [DATA_W-1:0]   mode_word;
    logic [DATA_W-1:0]   af_word [AF_WORDS];
    logic [DATA_W-1:0]   lock_word;
    logic [DATA_W-1:0]   rd_sel;
    logic [DATA_W-1:0]   rdata_d, rdata_q;

    pcl_lock_seq #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_en && (addr == ADDR_W'(ADDR_LOCK))),
        .wstrb     (wstrb),
        .wdata     (wdata),
        .lock_bits (lock_bits),
        .key_on    (key_on)
    );

    assign pin_frozen = key_on ? lock_bits : '0;

    pcl_cfg_word #(
        .DATA_W  (DATA_W),
        .FIELD_W (MODE_W)
    ) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (wr_en && (addr == ADDR_W'(ADDR_MODE))),
        .wstrb        (wstrb),
        .wdata        (wdata),
        .field_frozen (pin_frozen),
        .word         (mode_word)
    );

    for (genvar w = 0; w < AF_WORDS; w++) begin : g_af
        pcl_cfg_word #(
            .DATA_W  (DATA_W),
            .FIELD_W (AF_W)
        ) u_af (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_hit       (wr_en && (addr == ADDR_W'(ADDR_AF_BASE + w))),
            .wstrb        (wstrb),
            .wdata        (wdata),
            .field_frozen (pin_frozen[w*AF_PER_WORD +: AF_PER_WORD]),
            .word         (af_word[w])
        );
    end

    always_comb begin
        lock_word                 = '0;
        lock_word[NUM_PINS-1:0]   = lock_bits;
        lock_word[NUM_PINS]       = key_on;

        rd_sel = '0;
        if (addr == ADDR_W'(ADDR_LOCK)) begin
            rd_sel = lock_word;
        end
        if (addr == ADDR_W'(ADDR_MODE)) begin
            rd_sel = mode_word;
        end
        for (int w = 0; w < AF_WORDS; w++) begin
            if (addr == ADDR_W'(ADDR_AF_BASE + w)) begin
                rd_sel = af_word[w];
            end
        end

        rdata_d = rd_en ? rd_sel : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pcl_lock_checker.sv
module pcl_lock_checker #(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MODE_W   = 2,
    parameter int unsigned ADDR_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W/8-1:0] wstrb,
    input logic                key_on,
    input logic [NUM_PINS-1:0] lock_bits,
    input logic [NUM_PINS-1:0] pin_frozen,
    input logic [DATA_W-1:0]   mode_word
);
    logic [DATA_W-1:0] mode_frz_mask;
    logic              lock_wr;

    always_comb begin
        mode_frz_mask = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            mode_frz_mask[p*MODE_W +: MODE_W] = {MODE_W{pin_frozen[p]}};
        end
        lock_wr = wr_en && (addr == '0);
    end

    // R12: the key, once set, holds until reset
    a_r12_key_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        key_on |=> key_on);

    // R9: lock flags cannot move after the key is active
    a_r9_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        key_on |=> $stable(lock_bits));

    // R5: a partial-strobe write never activates the key
    a_r5_partial_no_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_on && lock_wr && !(&wstrb)) |=> !key_on);

    // R7: a write with the key bit clear never activates the key
    a_r7_key_low_no_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_on && lock_wr && !wdata[NUM_PINS]) |=> !key_on);

    // R3: the key rises only on a full-word key-set write
    a_r3_key_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_on) |-> $past(lock_wr && (&wstrb) && wdata[NUM_PINS]));

    // R11: frozen mode fields never change
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        key_on |=> (((mode_word ^ $past(mode_word)) & mode_frz_mask) == '0));
endmodule

bind pin_cfg_lock pcl_lock_checker #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .MODE_W   (MODE_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .wstrb      (wstrb),
    .key_on     (key_on),
    .lock_bits  (lock_bits),
    .pin_frozen (pin_frozen),
    .mode_word  (mode_word)
);

// File: tb/tb_pin_cfg_lock.sv
module tb_pin_cfg_lock;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic [31:0] rdata;
    logic [15:0] pin_frozen;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_issued = 1'b0;

    pin_cfg_lock dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .wstrb      (wstrb),
        .rdata      (rdata),
        .pin_frozen (pin_frozen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) rd_issued <= rst_n ? rd_en : 1'b0;

    // monitor: compares read data one edge after the request was sampled
    always @(negedge clk) begin
        if (rd_issued) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
        @(negedge clk);
        wr_en = 1'b0; wstrb = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_frz(input logic [15:0] e, input string t);
        n_tests++;
        if (pin_frozen !== e) begin
            n_fail++;
            $display("FAIL %s: pin_frozen actual %h expected %h", t, pin_frozen, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk_frz(16'h0000, "R1 frozen after reset");
        rd(2'd0, 32'h0, "R1 lock reg after reset");
        rd(2'd1, 32'h0, "R1 mode after reset");
        rd(2'd3, 32'h0, "R1 af hi after reset");

        // R10 config storage with strobes
        wr(2'd1, 32'hA5A5_5A5A, 4'hF);
        rd(2'd1, 32'hA5A5_5A5A, "R10 mode full write");
        wr(2'd1, 32'hFFFF_FFFF, 4'b0010);
        rd(2'd1, 32'hA5A5_FF5A, "R10 mode byte1 write");
        wr(2'd2, 32'h1234_5678, 4'hF);
        rd(2'd2, 32'h1234_5678, "R10 af lo write");

        // R2 lock flags under strobes
        wr(2'd0, 32'h0000_00F0, 4'b0001);
        rd(2'd0, 32'h0000_00F0, "R2 lock byte0");
        wr(2'd0, 32'hFFFE_1234, 4'b0011);
        rd(2'd0, 32'h0000_1234, "R2 lock two bytes, upper zero");

        // R7 single key write does not lock; R8 read in between
        wr(2'd0, 32'h0001_00FF, 4'hF);
        rd(2'd0, 32'h0000_00FF, "R7 lone key write");
        chk_frz(16'h0000, "R7 frozen after lone key write");
        wr(2'd0, 32'h0000_00FE, 4'hF);   // mismatch aborts -> idle

        // R4 mismatch on third write
        wr(2'd0, 32'h0001_00FE, 4'hF);
        wr(2'd0, 32'h0000_00FE, 4'hF);
        wr(2'd0, 32'h0001_00FC, 4'hF);
        rd(2'd0, 32'h0000_00FC, "R4 mismatch abort");
        chk_frz(16'h0000, "R4 frozen after abort");

        // R5 partial strobes on third write
        wr(2'd0, 32'h0001_000C, 4'hF);
        wr(2'd0, 32'h0000_000C, 4'hF);
        wr(2'd0, 32'h0001_000C, 4'b0111);
        rd(2'd0, 32'h0000_000C, "R5 partial strobe abort");

        // R6 order break 1,0,0 then 1,1
        wr(2'd0, 32'h0001_000C, 4'hF);
        wr(2'd0, 32'h0000_000C, 4'hF);
        wr(2'd0, 32'h0000_000C, 4'hF);
        rd(2'd0, 32'h0000_000C, "R6 order 1,0,0");
        wr(2'd0, 32'h0001_000C, 4'hF);
        wr(2'd0, 32'h0001_000C, 4'hF);
        rd(2'd0, 32'h0000_000C, "R6 order 1,1");

        // R7 key=0 from idle does not advance (0,1 must not lock)
        wr(2'd0, 32'h0000_8421, 4'hF);
        wr(2'd0, 32'h0001_8421, 4'hF);
        rd(2'd0, 32'h0000_8421, "R7 0,1 no lock; R8 read mid-sequence");
        wr(2'd0, 32'h0000_8421, 4'hF);
        rd(2'd0, 32'h0000_8421, "R8 read mid-sequence");
        wr(2'd0, 32'h0001_8421, 4'hF);
        chk_frz(16'h8421, "R3 frozen right after third write");
        rd(2'd0, 32'h0001_8421, "R3 key reads 1");

        // R9 writes ignored after lock
        wr(2'd0, 32'h0000_FFFF, 4'hF);
        rd(2'd0, 32'h0001_8421, "R9 write after lock");
        wr(2'd0, 32'h0001_00FF, 4'hF);
        wr(2'd0, 32'h0000_00FF, 4'hF);
        wr(2'd0, 32'h0001_00FF, 4'hF);
        rd(2'd0, 32'h0001_8421, "R9 second sequence");
        chk_frz(16'h8421, "R9 frozen unchanged");

        // R11 frozen fields drop writes
        wr(2'd1, 32'h0000_0000, 4'hF);
        rd(2'd1, 32'h8020_0C02, "R11 mode partial freeze");
        wr(2'd2, 32'hFFFF_FFFF, 4'hF);
        rd(2'd2, 32'hFF3F_FFF8, "R11 af lo partial freeze");
        wr(2'd3, 32'hFFFF_FFFF, 4'hF);
        rd(2'd3, 32'h0FFF_F0FF, "R11 af hi partial freeze");

        // R12 only reset clears
        do_reset();
        chk_frz(16'h0000, "R12 frozen cleared by reset");
        rd(2'd0, 32'h0000_0000, "R12 lock reg cleared by reset");
        wr(2'd0, 32'h0000_0003, 4'hF);
        rd(2'd0, 32'h0000_0003, "R12 lock flags writable again");

        repeat (3) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: pending reads actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule